// File: doc/BRIEF.md
# Memory Operation Ordering Tracker

This block keeps program-order bookkeeping for memory operations in an out-of-order core. Each memory operation is handed over at dispatch with an age tag and three flags (reads memory, writes memory, acts as a barrier). The block places it in a load queue, a store queue, or both. While the operation waits, the scheduler presents its tag on a query port. The block answers whether the operation may issue now, using fixed pairwise ordering rules between loads and stores and the barrier rules. When an operation finishes, its tag arrives on a completion port, and every record of it is dropped in that cycle.

A separate availability port tells the dispatch logic, before it commits, whether a candidate operation would fit. Each queue has a reported depth limit. A limit of zero makes that queue unbounded for reporting purposes. Physical storage is set by a slot-count parameter, and a zero limit relies on the environment to stay within it. A static configuration input relaxes load-after-store ordering when the software guarantees that no addresses alias. The block holds no addresses and no data.

Top module: `memord_tracker`

## Requirements
- R1: A queried operation that writes memory is not ready while any older tag remains in the store queue.
- R2: A queried operation that reads memory is not ready while an older tag remains in the store queue, unless `cfg_no_alias` is 1.
- R3: A reading operation is not held back by older non-barrier entries in the load queue.
- R4: A writing operation is not ready while an older tag remains in the load queue, for either value of `cfg_no_alias`.
- R5: A reading operation waits while an older load-queue entry is marked barrier, and a writing operation waits likewise for store-queue barriers. A barrier itself becomes ready only when no older entry remains in its own queue.
- R6: An operation with both read and write flags takes one entry in each queue. If it also has the barrier flag, it is a barrier in both queues.
- R7: `avail_status` is 0 when the candidate fits, 1 when it reads and the load queue is full, and 2 when it writes and the store queue is full. Code 1 wins when both queues are full. A candidate with neither flag always gets code 0.
- R8: A queue whose depth parameter is 0 never reports full on `avail_status`.
- R9: A completed tag leaves both queues at the next clock edge. A tag held in neither queue queries as not ready.
- R10: A dispatch that needs a full queue (or a queue with no free slot) allocates nothing in either queue and sets `proto_err`, which stays set until reset.
- R11: Ages are compared modulo 2^TAG_W, so a tag that wrapped past zero counts as younger than a tag just below the wrap point.
- R12: After reset both queues are empty, `proto_err` is 0 and `avail_status` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_no_alias | input | 1 | Static: loads may pass older stores |
| disp_valid | input | 1 | Dispatch strobe |
| disp_tag | input | TAG_W | Age tag of dispatched operation |
| disp_load | input | 1 | Dispatched operation reads memory |
| disp_store | input | 1 | Dispatched operation writes memory |
| disp_barrier | input | 1 | Dispatched operation is a barrier |
| cmp_valid | input | 1 | Completion strobe |
| cmp_tag | input | TAG_W | Tag of completed operation |
| qry_tag | input | TAG_W | Tag asked about |
| qry_ready | output | 1 | Queried operation may issue |
| chk_load | input | 1 | Candidate reads memory |
| chk_store | input | 1 | Candidate writes memory |
| avail_status | output | 2 | 0 fits, 1 load queue full, 2 store queue full |
| proto_err | output | 1 | Sticky overflow dispatch error |

## Verification
The readiness answer is checked with a store-then-store pair, a store-then-load pair under both alias settings, a load-then-load pair, and a load-then-store pair. Each pattern blocks under exactly one rule, so a swapped or dropped rule shows up as one wrong answer. Barrier chains are walked through completions one at a time to tell the "older barrier pending" rule from the "barrier must be oldest" rule. A combined read-write barrier confirms it holds both queues. A pair of tags either side of the wrap point separates modular from plain comparison. The queues are filled to their limits to check the priority of the status codes and that a rejected dispatch leaves no trace. A second instance with zero depths shows that full is never reported.

// File: rtl/memord_pkg.sv
package memord_pkg;

    localparam int unsigned TAG_MAX_W = 16;

    typedef enum logic [1:0] {
        AV_OK      = 2'd0,
        AV_LQ_FULL = 2'd1,
        AV_SQ_FULL = 2'd2
    } avail_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic bar;
    } memop_t;

    // a strictly older than b when (a - b) mod 2^w has its top bit set
    function automatic logic tag_older(input logic [TAG_MAX_W-1:0] a,
                                       input logic [TAG_MAX_W-1:0] b,
                                       input int unsigned w);
        logic [TAG_MAX_W-1:0] d;
        d = a - b;
        return ((d >> (w - 1)) & 16'd1) != 16'd0;
    endfunction

endpackage

// File: rtl/memord_queue.sv
module memord_queue
    import memord_pkg::*;
#(
    parameter int unsigned SLOTS = 6,
    parameter int unsigned DEPTH = 4,
    parameter int unsigned TAG_W = 4,
    localparam int unsigned CNT_W = $clog2(SLOTS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             alloc_i,
    input  logic [TAG_W-1:0] alloc_tag_i,
    input  logic             alloc_bar_i,
    input  logic             free_i,
    input  logic [TAG_W-1:0] free_tag_i,
    input  logic [TAG_W-1:0] look_tag_i,
    output logic             full_o,
    output logic             room_o,
    output logic             hit_o,
    output logic             hit_bar_o,
    output logic             older_any_o,
    output logic             older_bar_o,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] SLOTS_C = CNT_W'(SLOTS);
    localparam int unsigned      IDX_W   = (SLOTS > 1) ? $clog2(SLOTS) : 1;

    typedef struct packed {
        logic             vld;
        logic             bar;
        logic [TAG_W-1:0] tag;
    } slot_t;

    slot_t             slots [SLOTS];
    logic [IDX_W-1:0]  free_idx;
    logic              free_found;

    // first empty slot
    always_comb begin
        free_idx   = '0;
        free_found = 1'b0;
        for (int i = 0; i < SLOTS; i++) begin
            if (!slots[i].vld && !free_found) begin
                free_idx   = IDX_W'(i);
                free_found = 1'b1;
            end
        end
    end

    always_comb begin
        count_o = '0;
        for (int i = 0; i < SLOTS; i++) begin
            count_o = count_o + CNT_W'(slots[i].vld);
        end
    end

    generate
        if (DEPTH == 0) begin : g_unbounded
            assign full_o = 1'b0;
        end else begin : g_bounded
            assign full_o = (count_o >= DEPTH_C);
        end
    endgenerate

    assign room_o = (count_o < SLOTS_C);

    // look-up of the queried tag against every live slot
    always_comb begin
        hit_o       = 1'b0;
        hit_bar_o   = 1'b0;
        older_any_o = 1'b0;
        older_bar_o = 1'b0;
        for (int i = 0; i < SLOTS; i++) begin
            if (slots[i].vld) begin
                if (slots[i].tag == look_tag_i) begin
                    hit_o     = 1'b1;
                    hit_bar_o = hit_bar_o | slots[i].bar;
                end else if (tag_older(TAG_MAX_W'(slots[i].tag),
                                       TAG_MAX_W'(look_tag_i), TAG_W)) begin
                    older_any_o = 1'b1;
                    older_bar_o = older_bar_o | slots[i].bar;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SLOTS; i++) begin
                slots[i] <= '0;
            end
        end else begin
            for (int i = 0; i < SLOTS; i++) begin
                if (free_i && slots[i].vld && slots[i].tag == free_tag_i) begin
                    slots[i].vld <= 1'b0;
                    slots[i].bar <= 1'b0;
                end
            end
            if (alloc_i && free_found) begin
                slots[free_idx].vld <= 1'b1;
                slots[free_idx].bar <= alloc_bar_i;
                slots[free_idx].tag <= alloc_tag_i;
            end
        end
    end

    // R10: occupancy never passes the reported depth nor the slot count
    assert_depth_bound_R10: assert property (@(posedge clk) disable iff (rst)
        (count_o <= SLOTS_C) && (DEPTH == 0 || count_o <= DEPTH_C));

    // R10: the top never asks for a slot the queue cannot give
    assert_alloc_has_room_R10: assert property (@(posedge clk) disable iff (rst)
        alloc_i |-> room_o);

    // R9: a completed tag is gone one edge later
    assert_free_removes_R9: assert property (@(posedge clk) disable iff (rst)
        (free_i && !alloc_i && look_tag_i == free_tag_i) |=>
            ($past(look_tag_i) != look_tag_i) || !hit_o);

endmodule

// File: rtl/memord_rules.sv
module memord_rules (
    input  logic no_alias_i,
    input  logic lq_hit_i,
    input  logic lq_hit_bar_i,
    input  logic lq_older_any_i,
    input  logic lq_older_bar_i,
    input  logic sq_hit_i,
    input  logic sq_hit_bar_i,
    input  logic sq_older_any_i,
    input  logic sq_older_bar_i,
    output logic ready_o
);
    logic st_after_st;
    logic st_after_ld;
    logic ld_after_st;
    logic ld_bar_wait;
    logic st_bar_wait;

    always_comb begin
        st_after_st = sq_hit_i && sq_older_any_i;                   // R1
        ld_after_st = lq_hit_i && !no_alias_i && sq_older_any_i;    // R2
        st_after_ld = sq_hit_i && lq_older_any_i;                   // R4
        ld_bar_wait = lq_hit_i && (lq_older_bar_i ||
                                   (lq_hit_bar_i && lq_older_any_i)); // R5
        st_bar_wait = sq_hit_i && (sq_older_bar_i ||
                                   (sq_hit_bar_i && sq_older_any_i)); // R5
        ready_o = (lq_hit_i || sq_hit_i) && !st_after_st && !ld_after_st &&
                  !st_after_ld && !ld_bar_wait && !st_bar_wait;
    end

endmodule

// File: rtl/memord_tracker.sv
module memord_tracker
    import memord_pkg::*;
#(
    parameter int unsigned TAG_W    = 4,
    parameter int unsigned SLOTS    = 6,
    parameter int unsigned LQ_DEPTH = 4,
    parameter int unsigned SQ_DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_no_alias,
    input  logic             disp_valid,
    input  logic [TAG_W-1:0] disp_tag,
    input  logic             disp_load,
    input  logic             disp_store,
    input  logic             disp_barrier,
    input  logic             cmp_valid,
    input  logic [TAG_W-1:0] cmp_tag,
    input  logic [TAG_W-1:0] qry_tag,
    output logic             qry_ready,
    input  logic             chk_load,
    input  logic             chk_store,
    output logic [1:0]       avail_status,
    output logic             proto_err
);
    localparam int unsigned CNT_W = $clog2(SLOTS + 1);

    memop_t           dop;
    logic             lq_full, lq_room, lq_hit, lq_hit_bar, lq_older_any, lq_older_bar;
    logic             sq_full, sq_room, sq_hit, sq_hit_bar, sq_older_any, sq_older_bar;
    logic [CNT_W-1:0] lq_count, sq_count;
    logic             rejected, alloc_lq, alloc_sq, err_q;
    avail_e           status;

    assign dop = '{rd: disp_load, wr: disp_store, bar: disp_barrier};

    always_comb begin
        rejected = disp_valid &&
                   ((dop.rd && (lq_full || !lq_room)) ||
                    (dop.wr && (sq_full || !sq_room)));
        alloc_lq = disp_valid && dop.rd && !rejected;   // R6
        alloc_sq = disp_valid && dop.wr && !rejected;   // R6
    end

    memord_queue #(.SLOTS(SLOTS), .DEPTH(LQ_DEPTH), .TAG_W(TAG_W)) u_loadq (
        .clk, .rst,
        .alloc_i(alloc_lq), .alloc_tag_i(disp_tag), .alloc_bar_i(dop.bar),
        .free_i(cmp_valid), .free_tag_i(cmp_tag), .look_tag_i(qry_tag),
        .full_o(lq_full), .room_o(lq_room), .hit_o(lq_hit), .hit_bar_o(lq_hit_bar),
        .older_any_o(lq_older_any), .older_bar_o(lq_older_bar), .count_o(lq_count)
    );

    memord_queue #(.SLOTS(SLOTS), .DEPTH(SQ_DEPTH), .TAG_W(TAG_W)) u_storeq (
        .clk, .rst,
        .alloc_i(alloc_sq), .alloc_tag_i(disp_tag), .alloc_bar_i(dop.bar),
        .free_i(cmp_valid), .free_tag_i(cmp_tag), .look_tag_i(qry_tag),
        .full_o(sq_full), .room_o(sq_room), .hit_o(sq_hit), .hit_bar_o(sq_hit_bar),
        .older_any_o(sq_older_any), .older_bar_o(sq_older_bar), .count_o(sq_count)
    );

    memord_rules u_rules (
        .no_alias_i(cfg_no_alias),
        .lq_hit_i(lq_hit), .lq_hit_bar_i(lq_hit_bar),
        .lq_older_any_i(lq_older_any), .lq_older_bar_i(lq_older_bar),
        .sq_hit_i(sq_hit), .sq_hit_bar_i(sq_hit_bar),
        .sq_older_any_i(sq_older_any), .sq_older_bar_i(sq_older_bar),
        .ready_o(qry_ready)
    );

    // R7: load-queue-full is tested first
    always_comb begin
        if (chk_load && lq_full)       status = AV_LQ_FULL;
        else if (chk_store && sq_full) status = AV_SQ_FULL;
        else                           status = AV_OK;
    end
    assign avail_status = status;

    always_ff @(posedge clk) begin
        if (rst) err_q <= 1'b0;
        else     err_q <= err_q | rejected;
    end
    assign proto_err = err_q;

    // R10: error stays set once raised
    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        proto_err |=> proto_err);

    // R10: a rejected dispatch raises the error and leaves both queues untouched
    assert_reject_no_alloc_R10: assert property (@(posedge clk) disable iff (rst)
        (rejected && !cmp_valid) |=>
            proto_err && $stable(lq_count) && $stable(sq_count));

    // R7: only the three defined codes appear
    assert_status_code_R7: assert property (@(posedge clk) disable iff (rst)
        avail_status != 2'd3);

    // R9: an unknown tag is never reported ready
    assert_ready_needs_entry_R9: assert property (@(posedge clk) disable iff (rst)
        qry_ready |-> (lq_hit || sq_hit));

    // R6: a combined operation lands in both queues together
    assert_dual_alloc_R6: assert property (@(posedge clk) disable iff (rst)
        (disp_valid && disp_load && disp_store && !rejected && !cmp_valid) |=>
            (lq_count == $past(lq_count) + CNT_W'(1)) &&
            (sq_count == $past(sq_count) + CNT_W'(1)));

endmodule

// File: tb/memord_tracker_bench.sv
module memord_tracker_bench;
    localparam int TAG_W = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cfg_no_alias = 1'b0;
    logic             disp_valid = 1'b0;
    logic [TAG_W-1:0] disp_tag = '0;
    logic             disp_load = 1'b0, disp_store = 1'b0, disp_barrier = 1'b0;
    logic             cmp_valid = 1'b0;
    logic [TAG_W-1:0] cmp_tag = '0;
    logic [TAG_W-1:0] qry_tag = '0;
    logic             qry_ready;
    logic             chk_load = 1'b0, chk_store = 1'b0;
    logic [1:0]       avail_status;
    logic             proto_err;

    logic             b_disp_valid = 1'b0;
    logic [TAG_W-1:0] b_disp_tag = '0;
    logic             b_chk_load = 1'b0, b_chk_store = 1'b0;
    logic             b_qry_ready;
    logic [1:0]       b_status;
    logic             b_err;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    memord_tracker #(.TAG_W(TAG_W), .SLOTS(6), .LQ_DEPTH(4), .SQ_DEPTH(2)) u_memord_tracker (
        .clk, .rst, .cfg_no_alias, .disp_valid, .disp_tag, .disp_load, .disp_store,
        .disp_barrier, .cmp_valid, .cmp_tag, .qry_tag, .qry_ready, .chk_load,
        .chk_store, .avail_status, .proto_err
    );

    memord_tracker #(.TAG_W(TAG_W), .SLOTS(4), .LQ_DEPTH(0), .SQ_DEPTH(0)) u_memord_tracker_unb (
        .clk, .rst, .cfg_no_alias(1'b0), .disp_valid(b_disp_valid), .disp_tag(b_disp_tag),
        .disp_load(1'b1), .disp_store(1'b1), .disp_barrier(1'b0), .cmp_valid(1'b0),
        .cmp_tag('0), .qry_tag('0), .qry_ready(b_qry_ready), .chk_load(b_chk_load),
        .chk_store(b_chk_store), .avail_status(b_status), .proto_err(b_err)
    );

    task automatic check(input int act, input int exp, input string what);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic dispatch(input int tag, input logic l, input logic s, input logic b);
        @(negedge clk);
        disp_valid = 1'b1; disp_tag = TAG_W'(tag);
        disp_load = l; disp_store = s; disp_barrier = b;
        @(negedge clk);
        disp_valid = 1'b0;
    endtask

    task automatic complete(input int tag);
        @(negedge clk);
        cmp_valid = 1'b1; cmp_tag = TAG_W'(tag);
        @(negedge clk);
        cmp_valid = 1'b0;
    endtask

    task automatic ask(input int tag, input int exp, input string what);
        qry_tag = TAG_W'(tag);
        #1;
        check(int'(qry_ready), exp, what);
    endtask

    task automatic status(input logic l, input logic s, input int exp, input string what);
        chk_load = l; chk_store = s;
        #1;
        check(int'(avail_status), exp, what);
        chk_load = 1'b0; chk_store = 1'b0;
    endtask

    task automatic t_reset;
        status(1'b1, 1'b1, 0, "R12 status after reset");
        check(int'(proto_err), 0, "R12 error after reset");
        ask(0, 0, "R12 empty queue query");
    endtask

    task automatic t_store_store;
        dispatch(1, 1'b0, 1'b1, 1'b0);
        dispatch(2, 1'b0, 1'b1, 1'b0);
        ask(1, 1, "R1 oldest store ready");
        ask(2, 0, "R1 younger store blocked");
        complete(1);
        ask(1, 0, "R9 completed tag gone");
        ask(2, 1, "R1 store free after older completes");
        complete(2);
    endtask

    task automatic t_load_after_store;
        dispatch(3, 1'b0, 1'b1, 1'b0);
        dispatch(4, 1'b1, 1'b0, 1'b0);
        ask(4, 0, "R2 load behind store, aliasing");
        cfg_no_alias = 1'b1;
        ask(4, 1, "R2 load passes store, no alias");
        cfg_no_alias = 1'b0;
        complete(3); complete(4);
    endtask

    task automatic t_load_load;
        dispatch(5, 1'b1, 1'b0, 1'b0);
        dispatch(6, 1'b1, 1'b0, 1'b0);
        ask(6, 1, "R3 load passes older load");
        complete(5); complete(6);
    endtask

    task automatic t_store_after_load;
        cfg_no_alias = 1'b1;
        dispatch(7, 1'b1, 1'b0, 1'b0);
        dispatch(8, 1'b0, 1'b1, 1'b0);
        ask(8, 0, "R4 store behind load, no alias set");
        complete(7);
        ask(8, 1, "R4 store free after load completes");
        complete(8);
        cfg_no_alias = 1'b0;
    endtask

    task automatic t_barrier;
        dispatch(9, 1'b1, 1'b0, 1'b0);
        dispatch(10, 1'b1, 1'b0, 1'b1);
        dispatch(11, 1'b1, 1'b0, 1'b0);
        ask(9, 1, "R5 load before barrier ready");
        ask(10, 0, "R5 barrier waits to be oldest");
        ask(11, 0, "R5 load behind pending barrier");
        complete(9);
        ask(10, 1, "R5 barrier ready once oldest");
        ask(11, 0, "R5 load still behind barrier");
        complete(10);
        ask(11, 1, "R5 load free after barrier");
        complete(11);
    endtask

    task automatic t_dual;
        dispatch(12, 1'b1, 1'b1, 1'b1);
        dispatch(13, 1'b1, 1'b0, 1'b0);
        dispatch(14, 1'b0, 1'b1, 1'b0);
        cfg_no_alias = 1'b1;
        ask(12, 1, "R6 dual barrier alone ready");
        ask(13, 0, "R6 load held by dual op load barrier");
        ask(14, 0, "R6 store held by dual op");
        complete(12);
        ask(13, 1, "R6 load free after dual op");
        ask(14, 0, "R4 store still behind load");
        complete(13); complete(14);
        cfg_no_alias = 1'b0;
    endtask

    task automatic t_wrap;
        dispatch(14, 1'b0, 1'b1, 1'b0);
        dispatch(1, 1'b1, 1'b0, 1'b0);
        ask(14, 1, "R11 pre-wrap store is oldest");
        ask(1, 0, "R11 wrapped load is younger");
        complete(14); complete(1);
    endtask

    task automatic t_full;
        dispatch(2, 1'b0, 1'b1, 1'b0);
        dispatch(3, 1'b0, 1'b1, 1'b0);
        status(1'b0, 1'b1, 2, "R7 store queue full");
        status(1'b1, 1'b1, 2, "R7 dual candidate, only SQ full");
        status(1'b1, 1'b0, 0, "R7 load fits");
        for (int t = 4; t < 8; t++) dispatch(t, 1'b1, 1'b0, 1'b0);
        status(1'b1, 1'b1, 1, "R7 load-full has priority");
        status(1'b0, 1'b0, 0, "R7 non-memory candidate");
        check(int'(proto_err), 0, "R10 no error yet");
        dispatch(8, 1'b0, 1'b1, 1'b0);
        check(int'(proto_err), 1, "R10 overflow raises error");
        dispatch(9, 1'b1, 1'b1, 1'b0);
        complete(2);
        status(1'b0, 1'b1, 0, "R10 rejected stores not allocated");
        ask(8, 0, "R10 rejected tag absent");
        check(int'(proto_err), 1, "R10 error sticky");
        complete(3);
        for (int t = 4; t < 8; t++) complete(t);
        status(1'b1, 1'b1, 0, "R9 queues drained");
    endtask

    task automatic t_unbounded;
        for (int t = 0; t < 4; t++) begin
            @(negedge clk);
            b_disp_valid = 1'b1; b_disp_tag = TAG_W'(t);
            @(negedge clk);
            b_disp_valid = 1'b0;
        end
        b_chk_load = 1'b1; b_chk_store = 1'b1;
        #1;
        check(int'(b_status), 0, "R8 zero depth never full");
        check(int'(b_err), 0, "R8 no error within slots");
        b_chk_load = 1'b0; b_chk_store = 1'b0;
    endtask

    task automatic t_rereset;
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check(int'(proto_err), 0, "R12 reset clears error");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_store_store();
        t_load_after_store();
        t_load_load();
        t_store_after_load();
        t_barrier();
        t_dual();
        t_wrap();
        t_full();
        t_unbounded();
        t_rereset();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: got 0 expected 1 (run ended)");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule